// File: doc/BRIEF.md
# CSD Coefficient Shift-Add Multiplier

This block scales a signed audio sample by a filter coefficient that is held as a short chain of canonical-signed-digit terms rather than as a binary number. Each term is a 4-bit nibble carrying a sign and a shift code. The shift of every term is counted from the position of the term before it, so the first term marks the most significant one of the coefficient and each later term marks a less significant one. The block walks the chain one term per clock. It keeps a running right-shift total and adds or subtracts the arithmetically shifted sample into an accumulator.

A host pulses `start` with the sample, the packed coefficient, the term count and the unity flag valid in the same cycle. The block then runs for as many clocks as there are terms, pulses `done` for one cycle and holds `product` until the next result. With the unity flag set, the coefficient gains an implicit leading value of one, so the unshifted sample seeds the accumulator. The control pins are plain strobes. There is no back-pressure: a `start` that arrives while a job is running is dropped, and `product` is simply held until it is overwritten.

Top module: `csd_mult`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: Term k (k = 1..4) is taken from `coef_word` bits [4k-1:4k-4], so term 1 is bits [3:0]. Within a nibble, bit 3 is the sign (0 adds, 1 subtracts) and bits [2:0] are the shift code.
- R3: The shift code is a plain binary count from 0 to 7. Term k is weighted by 2^-(m1+...+mk), where mj is the shift code of term j.
- R4: The sample is scaled to `xs` = sample·2^5, which places 5 fraction bits in the 24-bit `product`. The result is the sum over the applied terms of ±(xs >>> (m1+...+mk)), using an arithmetic right shift that floors toward minus infinity.
- R5: When `unity_mode` is 1 at start, xs is added to the sum once with no shift.
- R6: `term_cnt` holds the number of terms minus one (0 means 1 term, 3 means 4 terms). Nibbles beyond that count have no effect on `product`.
- R7: With N terms, `done` is high exactly N clock edges after the edge that accepts `start`, and it stays high for one cycle.
- R8: A `start` that arrives while a job is running is ignored. Neither its inputs nor its timing affect the running result.
- R9: `product` changes only on the edge that raises `done`, and it holds its value otherwise.
- R10: For any input, the result fits in 24 bits without wrapping. The worst case is the full-scale sample with unity and four zero-shift terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job strobe; taken only when idle |
| sample | input | 16 | Two's-complement sample |
| coef_word | input | 16 | Four packed CSD terms, term 1 in the low nibble |
| term_cnt | input | 2 | Number of terms minus one |
| unity_mode | input | 1 | Adds the implicit leading one |
| product | output | 24 | Signed result with 5 fraction bits, held between jobs |
| done | output | 1 | One-cycle pulse when a result is written |

## Verification
A job with N terms accepted on one edge raises `done` and updates `product` on the Nth edge after that. A start sampled on that same edge is refused, because the block is still busy then. The bench keeps its own behavioural model with a countdown per job. The model is stepped on every rising edge, and both outputs are compared with it on every falling edge, so an early, late or repeated `done` shows up in the exact cycle it occurs. The bench holds `start` high through busy periods with changing operands to show that those operands are dropped.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int unsigned TERM_BITS = 4;
  localparam int unsigned CODE_BITS = 3;

  typedef struct packed {
    logic                 neg;
    logic [CODE_BITS-1:0] code;
  } csd_term_t;
endpackage

// File: rtl/csd_term_select.sv
module csd_term_select #(
  parameter int unsigned MAX_TERMS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [MAX_TERMS*csd_pkg::TERM_BITS-1:0] coef_word,
  input  logic [IDX_W-1:0]                        idx,
  output csd_pkg::csd_term_t                      term
);
  csd_pkg::csd_term_t terms [MAX_TERMS];

  for (genvar g = 0; g < MAX_TERMS; g++) begin : g_unpack
    assign terms[g] = csd_pkg::csd_term_t'(
      coef_word[g*csd_pkg::TERM_BITS +: csd_pkg::TERM_BITS]);
  end

  always_comb begin
    term = terms[0];
    for (int i = 0; i < MAX_TERMS; i++) begin
      if (IDX_W'(i) == idx) term = terms[i];
    end
  end
endmodule

// File: rtl/csd_shift_acc.sv
module csd_shift_acc #(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned SHW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ACC_W-1:0]   load_val,
  input  logic               step,
  input  csd_pkg::csd_term_t term,
  input  logic [ACC_W-1:0]   base,
  output logic [ACC_W-1:0]   acc_next
);
  logic [SHW-1:0]   sh_q;
  logic [SHW-1:0]   sh_next;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] shifted;

  always_comb begin
    sh_next  = sh_q + SHW'(term.code);
    shifted  = ACC_W'($signed(base) >>> sh_next);
    acc_next = term.neg ? (acc_q - shifted) : (acc_q + shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      acc_q <= '0;
    end else if (load) begin
      sh_q  <= '0;
      acc_q <= load_val;
    end else if (step) begin
      sh_q  <= sh_next;
      acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/csd_ctrl.sv
module csd_ctrl #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] count,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] cnt_q;

  assign last = busy && (idx == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      idx   <= '0;
      cnt_q <= count;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/csd_mult.sv
module csd_mult #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned PROD_W    = 24,
  parameter int unsigned MAX_TERMS = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  input  logic [SAMPLE_W-1:0]                     sample,
  input  logic [MAX_TERMS*csd_pkg::TERM_BITS-1:0] coef_word,
  input  logic [$clog2(MAX_TERMS)-1:0]            term_cnt,
  input  logic                                    unity_mode,
  output logic [PROD_W-1:0]                       product,
  output logic                                    done
);
  localparam int unsigned IDX_W  = $clog2(MAX_TERMS);
  localparam int unsigned HEAD_W = $clog2(MAX_TERMS + 1);
  localparam int unsigned FRAC_W = PROD_W - SAMPLE_W - HEAD_W;
  localparam int unsigned SHW    = $clog2(((1 << csd_pkg::CODE_BITS) - 1) * MAX_TERMS + 1);
  localparam int unsigned COEF_W = MAX_TERMS * csd_pkg::TERM_BITS;

  logic               busy;
  logic               last;
  logic               accept;
  logic [IDX_W-1:0]   idx;
  logic [PROD_W-1:0]  scaled_in;
  logic [PROD_W-1:0]  base_q;
  logic [COEF_W-1:0]  coef_q;
  logic [PROD_W-1:0]  acc_next;
  csd_pkg::csd_term_t term;

  assign accept    = start && !busy;
  assign scaled_in = {{HEAD_W{sample[SAMPLE_W-1]}}, sample, {FRAC_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      coef_q <= '0;
    end else if (accept) begin
      base_q <= scaled_in;
      coef_q <= coef_word;
    end
  end

  csd_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .count(term_cnt),
    .busy(busy), .idx(idx), .last(last)
  );

  csd_term_select #(.MAX_TERMS(MAX_TERMS), .IDX_W(IDX_W)) u_sel (
    .coef_word(coef_q), .idx(idx), .term(term)
  );

  csd_shift_acc #(.ACC_W(PROD_W), .SHW(SHW)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val(unity_mode ? scaled_in : '0),
    .step(busy), .term(term), .base(base_q), .acc_next(acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (last) product <= acc_next;
    end
  end
endmodule

// File: rtl/csd_mult_chk.sv
module csd_mult_chk #(
  parameter int unsigned PROD_W = 24,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [IDX_W-1:0]  term_cnt,
  input logic [PROD_W-1:0] product,
  input logic              done
);
  logic [IDX_W:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rem <= '0;
    else if (rem != '0)          rem <= rem - 1'b1;
    else if (start)              rem <= {1'b0, term_cnt} + 1'b1;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == 1) |=> done);
  p_done_only_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rem) == 1));
  p_busy_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rem > 1) |=> !done);
  p_product_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
endmodule

bind csd_mult csd_mult_chk #(.PROD_W(PROD_W), .IDX_W($clog2(MAX_TERMS))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .term_cnt(term_cnt),
  .product(product), .done(done)
);

// File: tb/csd_mult_test.sv
module csd_mult_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] sample = '0;
  logic [15:0] coef_word = '0;
  logic [1:0]  term_cnt = '0;
  logic        unity_mode = 1'b0;
  logic [23:0] product;
  logic        done;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    armed = 1'b0;

  int    m_rem = 0;
  bit    m_done = 1'b0;
  int    m_prod = 0;
  int    m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csd_mult uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample(sample),
    .coef_word(coef_word), .term_cnt(term_cnt), .unity_mode(unity_mode),
    .product(product), .done(done)
  );

  function automatic int ref_value(input logic [15:0] x, input logic [15:0] cw,
                                   input int nterms, input bit uni);
    int xs = $signed(x) * 32;
    int acc = uni ? xs : 0;
    int sh = 0;
    for (int k = 0; k < nterms; k++) begin
      sh += int'(cw[4*k +: 3]);
      if (cw[4*k+3]) acc -= (xs >>> sh);
      else           acc += (xs >>> sh);
    end
    return acc;
  endfunction

  always @(posedge clk) begin
    armed = 1'b1;
    if (!rst_n) begin
      m_rem = 0; m_done = 1'b0; m_prod = 0;
    end else begin
      m_done = 1'b0;
      if (m_rem != 0) begin
        m_rem--;
        if (m_rem == 0) begin m_done = 1'b1; m_prod = m_pend; end
      end else if (start) begin
        m_pend = ref_value(sample, coef_word, int'(term_cnt) + 1, unity_mode);
        m_rem  = int'(term_cnt) + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      n_cmp++;
      if (done !== m_done || $signed(product) !== m_prod) begin
        n_bad++;
        $display("FAIL %s: done=%0b product=%0d expected done=%0b product=%0d",
                 tag, done, $signed(product), m_done, m_prod);
      end
    end
  end

  task automatic job(input logic [15:0] x, input logic [15:0] cw,
                     input logic [1:0] cnt, input bit uni, input string t);
    tag = t;
    @(negedge clk);
    sample = x; coef_word = cw; term_cnt = cnt; unity_mode = uni; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (int'(cnt) + 2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    n_cmp++;
    if (done !== 1'b0 || product !== 24'd0) begin
      n_bad++;
      $display("FAIL R1: done=%0b product=%0d expected 0/0", done, product);
    end
    rst_n = 1'b1;
    // R2 R3: single terms, sign and shift codes
    for (int s = 0; s < 8; s++) begin
      job(16'd1000, 16'(s), 2'd0, 1'b0, "R3");
      job(16'hF830, 16'(8 + s), 2'd0, 1'b0, "R2");
    end
    // R4: multi-term mixes, odd samples to hit flooring
    job(16'd12345, 16'h3A21, 2'd3, 1'b0, "R4");
    job(16'hFFFF, 16'h7777, 2'd3, 1'b0, "R4");
    job(16'h8001, 16'h1C93, 2'd2, 1'b0, "R4");
    job(16'd7, 16'h0123, 2'd3, 1'b0, "R4");
    // R5: unity variant
    job(16'd20000, 16'h0092, 2'd1, 1'b1, "R5");
    job(16'hC000, 16'h0009, 2'd0, 1'b1, "R5");
    // R6: counts with garbage above the count
    job(16'd3000, 16'hFF21, 2'd1, 1'b0, "R6");
    job(16'd3000, 16'hAB21, 2'd1, 1'b0, "R6");
    job(16'd3000, 16'hF432, 2'd2, 1'b0, "R6");
    // R7: back-to-back jobs with start held across done
    tag = "R7";
    @(negedge clk);
    sample = 16'd555; coef_word = 16'h0001; term_cnt = 2'd0; unity_mode = 1'b0; start = 1'b1;
    repeat (6) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R8: start held high with changing operands during a 4-term job
    tag = "R8";
    @(negedge clk);
    sample = 16'd9000; coef_word = 16'h1111; term_cnt = 2'd3; unity_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    sample = 16'h9999; coef_word = 16'h8888; term_cnt = 2'd0; unity_mode = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    // R9: idle hold with inputs moving and no start
    tag = "R9";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sample = 16'(i * 4099); coef_word = 16'(i * 7919); unity_mode = i[0];
    end
    // R10: extremes
    job(16'h8000, 16'h0000, 2'd3, 1'b1, "R10");
    job(16'h7FFF, 16'h0000, 2'd3, 1'b1, "R10");
    job(16'h8000, 16'h8888, 2'd3, 1'b1, "R10");
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule